// File: doc/BRIEF.md
# HSYNC-Locked Half-Line Tick Generator

This block produces two single-cycle ticks for each horizontal video line. It locks to the active level of the horizontal sync input and then times the rest of the line from a programmed half-line count, rather than reacting to each sync edge. The first tick falls just before mid-line. The second tick is placed so that a register stage clocked one cycle after it changes its output in step with the next sync edge. This removes the edge-to-output round trip that a purely reactive design would have. After the second tick the block waits for sync again, so it re-locks on every line.

The half-line count is the half-line period in clock cycles minus a fixed overhead of 11 cycles. The overhead absorbs the synchronizer stages and the internal load and compare cycles. The count is captured only while the block is disabled. When the block is enabled it starts by waiting for sync. A polarity input selects whether sync is active high or active low.

Top module: `halfLineTick`

## Requirements
- R1: While reset is held, and after reset while `enable` is low, `tick` is 0.
- R2: The active sync level is `hsync`=1 when `hsyncPosPol`=1 and `hsync`=0 when `hsyncPosPol`=0. The inactive level never starts a line.
- R3: With captured count H, the first tick of a line is high in the cycle that follows clock edge e0+H+10, where e0 is the first rising edge that samples the active sync level while the block waits for sync.
- R4: The second tick of a line is high exactly H+11 cycles after the first.
- R5: Each tick is high for exactly one cycle.
- R6: After the second tick the block issues no further ticks until the sync input is active again.
- R7: `halfCount` is captured only on edges where `enable` is low. Changes made while enabled do not affect tick timing.
- R8: `enable` low stops all ticks from the next cycle on. Raising `enable` starts the block waiting for sync, so no tick occurs until sync is active.
- R9: Sync activity while a line is being timed, including extra active pulses, does not restart or shift the ticks of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low stops ticks and allows the count to be loaded |
| hsyncPosPol | input | 1 | 1: sync active high, 0: sync active low |
| hsync | input | 1 | Asynchronous horizontal sync |
| halfCount | input | CountW | Half-line period in cycles minus 11 |
| tick | output | 1 | One-cycle tick, two per line |

## Verification
Sync goes through two synchronizer flops and one state-load edge before the counter runs. The first tick is therefore due H+10 edges after the edge that first samples sync, and the second tick H+11 cycles after the first. The bench drives inputs on falling edges and keeps a cycle counter that advances on rising edges. It logs the counter value at each falling edge where `tick` is high, and compares the logged values with these offsets, computed from the count it programmed. Ignore-type requirements (R6, R7, R9) are checked the same way, through the tick log: no extra entries may appear, and the logged positions must not move.

// File: rtl/halfLineTickPkg.sv
package halfLineTickPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FIRST = 2'd2,
    ST_SECOND = 2'd3
  } tickState_t;

  typedef struct packed {
    logic loadCfg;
    logic loadFirst;
    logic loadSecond;
    logic dec;
  } tickStrobe_t;
endpackage

// File: rtl/halfLineTickDp.sv
module halfLineTickDp
  import halfLineTickPkg::*;
#(
  parameter int CountW     = 16,
  parameter int SyncStages = 2,
  parameter int FirstPad   = 8,
  parameter int SecondPad  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsync,
  input  logic              hsyncPosPol,
  input  logic [CountW-1:0] halfCount,
  input  tickStrobe_t       strobe,
  output logic              hsActive,
  output logic              cntZero
);
  localparam int CntW = CountW + 1;

  logic [SyncStages-1:0] syncChain;
  logic [CountW-1:0]     cfgReg;
  logic [CntW-1:0]       cnt;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SyncStages-2:0], hsync};
  end

  assign hsActive = hsyncPosPol ? syncChain[SyncStages-1] : ~syncChain[SyncStages-1];

  always_ff @(posedge clk) begin
    if (!rstN)               cfgReg <= '0;
    else if (strobe.loadCfg) cfgReg <= halfCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  cnt <= '0;
    else if (strobe.loadFirst)  cnt <= {1'b0, cfgReg} + CntW'(FirstPad);
    else if (strobe.loadSecond) cnt <= {1'b0, cfgReg} + CntW'(SecondPad);
    else if (strobe.dec)        cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> !cntZero); // R4
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.loadFirst, strobe.loadSecond, strobe.dec}) <= 1); // R3
endmodule

// File: rtl/halfLineTickCtl.sv
module halfLineTickCtl
  import halfLineTickPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        hsActive,
  input  logic        cntZero,
  output tickStrobe_t strobe,
  output logic        tick
);
  tickState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.loadCfg = !enable;
    if (!enable) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stateNext = ST_WAIT;
        ST_WAIT: if (hsActive) begin
          stateNext = ST_FIRST;
          strobe.loadFirst = 1'b1;
        end
        ST_FIRST: if (cntZero) begin
          stateNext = ST_SECOND;
          strobe.loadSecond = 1'b1;
        end else begin
          strobe.dec = 1'b1;
        end
        ST_SECOND: if (cntZero) stateNext = ST_WAIT;
                   else strobe.dec = 1'b1;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign tick = ((state == ST_FIRST) || (state == ST_SECOND)) && cntZero;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R5
  AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !tick); // R8
  AST_FIRST_TO_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_FIRST && cntZero) |=> (state == ST_SECOND && !cntZero)); // R4
  AST_WAIT_FOR_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_WAIT && !hsActive) |=> state == ST_WAIT); // R6
endmodule

// File: rtl/halfLineTick.sv
module halfLineTick
  import halfLineTickPkg::*;
#(
  parameter int CountW     = 16,
  parameter int SyncStages = 2,
  parameter int Overhead   = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              hsyncPosPol,
  input  logic              hsync,
  input  logic [CountW-1:0] halfCount,
  output logic              tick
);
  localparam int SecondPad = Overhead - 1;
  localparam int FirstPad  = Overhead - 1 - SyncStages;

  tickStrobe_t strobe;
  logic        hsActive;
  logic        cntZero;

  halfLineTickDp #(
    .CountW(CountW), .SyncStages(SyncStages),
    .FirstPad(FirstPad), .SecondPad(SecondPad)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hsync(hsync), .hsyncPosPol(hsyncPosPol),
    .halfCount(halfCount), .strobe(strobe), .hsActive(hsActive), .cntZero(cntZero)
  );

  halfLineTickCtl u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .hsActive(hsActive),
    .cntZero(cntZero), .strobe(strobe), .tick(tick)
  );

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable)) |-> !strobe.loadCfg); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !tick); // R1
endmodule

// File: tb/halfLineTick_tb.sv
module halfLineTick_tb;
  localparam int CountW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic hsyncPosPol = 1'b1;
  logic hsync = 1'b0;
  logic [CountW-1:0] halfCount = '0;
  logic tick;

  int cyc = 0;
  int nTicks = 0;
  int tickAt [2];
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  halfLineTick #(.CountW(CountW)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .hsyncPosPol(hsyncPosPol),
    .hsync(hsync), .halfCount(halfCount), .tick(tick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tick) begin
      if (nTicks < 2) tickAt[nTicks] = cyc;
      nTicks = nTicks + 1;
    end
  end

  function automatic int expFirst(int c0, int h);
    return c0 + 1 + h + 10;
  endfunction

  function automatic int expSecond(int c0, int h);
    return expFirst(c0, h) + h + 11;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Disable, load count and polarity, then enable.
  task automatic setup(input int h, input logic pol);
    enable = 1'b0;
    hsyncPosPol = pol;
    hsync = ~pol;
    halfCount = CountW'(h);
    cycles(3);
    enable = 1'b1;
    nTicks = 0;
    cycles(6);
    check(nTicks == 0, "R8 no tick before sync", nTicks, 0);
  endtask

  // One line; hsync goes active now. h is the count the DUT should use.
  task automatic line(input int h, input bit glitch, input int newCount);
    int c0;
    int w;
    c0 = cyc;
    nTicks = 0;
    w = 2 + int'($urandom_range(0, 4));
    hsync = hsyncPosPol;
    if (newCount >= 0) halfCount = CountW'(newCount);
    cycles(w);
    hsync = ~hsyncPosPol;
    if (glitch) begin
      cycles(2);
      hsync = hsyncPosPol;
      cycles(1);
      hsync = ~hsyncPosPol;
    end
    while (cyc < expSecond(c0, h) + 2) @(negedge clk);
    check(nTicks == 2, "R3/R4 tick count", nTicks, 2);
    check(tickAt[0] == expFirst(c0, h), "R3 first tick", tickAt[0], expFirst(c0, h));
    check(tickAt[1] - tickAt[0] == h + 11, "R4 spacing", tickAt[1] - tickAt[0], h + 11);
    cycles(1 + int'($urandom_range(0, 3)));
    check(nTicks == 2, "R6 quiet until sync", nTicks, 2);
  endtask

  initial begin
    int seedVal;
    seedVal = int'($urandom(32'd4711));
    cycles(3);
    check(tick == 1'b0, "R1 reset", int'(tick), 0);
    rstN = 1'b1;
    nTicks = 0;
    cycles(5);
    check(nTicks == 0, "R1 idle after reset", nTicks, 0);

    // Directed: smallest count, positive polarity.
    setup(0, 1'b1);
    line(0, 1'b0, -1);
    // Directed: negative polarity (R2), idle level 1 gives no tick.
    setup(7, 1'b0);
    line(7, 1'b0, -1);
    // R7: count change while enabled ignored.
    setup(20, 1'b1);
    line(20, 1'b0, 33);
    line(20, 1'b0, -1);
    // R9: extra sync pulse mid-line ignored.
    setup(15, 1'b1);
    line(15, 1'b1, -1);
    // R6: long quiet stretch without sync.
    nTicks = 0;
    cycles(80);
    check(nTicks == 0, "R6 long quiet", nTicks, 0);
    // R8: disable mid-line stops ticks.
    setup(30, 1'b1);
    hsync = 1'b1;
    cycles(3);
    hsync = 1'b0;
    cycles(5);
    enable = 1'b0;
    nTicks = 0;
    cycles(90);
    check(nTicks == 0, "R8 disable mid-line", nTicks, 0);

    // Random trials.
    for (int t = 0; t < 12; t++) begin
      int h;
      logic pol;
      h = int'($urandom_range(0, 60));
      pol = 1'($urandom_range(0, 1));
      setup(h, pol);
      for (int l = 0; l < 4; l++) begin
        line(h, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 60)) : -1);
      end
    end
    done = 1'b1;
  end

  initial begin
    int lim;
    lim = 0;
    while (!done && lim < 150000) begin
      @(posedge clk);
      lim++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", lim, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule